// File: doc/BRIEF.md
# MSI Capture and Interrupt Aggregator

This block sits beside a PCIe root port and turns inbound message-signalled interrupt writes into one interrupt line. Software gives each of eight vector sets a 64-bit capture address. When an inbound memory write hits the address of an enabled set, the low five bits of the write data pick one of that set's 32 vectors, and the matching bit of the set's sticky status word is raised.

Each set has a per-vector enable word. When the set is enabled and any vector is both pending and enabled, the set's summary bit is raised in a top-level status word. Four legacy INTx level lines share that same word. A top-level enable word masks it, and the single interrupt output is the OR of everything that is both pending and enabled.

Software clears per-vector status and summary bits independently, by writing ones. A simple register port exposes all of the registers.

Top module: `msi_irq_aggregator`

## Requirements
- R1: After reset every register reads as zero and `irq_out` is low.
- R2: The low capture word of set i is read/write at 0xC00+16*i, its high word at 0xC80+4*i, and its vector enable word at 0xC00+16*i+8.
- R3: A capture write whose 64-bit address equals set i's capture address, with set-enable bit i (register 0x190, bit i) set, raises bit (data mod 32) of set i's status word at 0xC00+16*i+4. The bit is visible after the capturing clock edge, and bits already set are kept.
- R4: A capture write that matches no enabled set leaves every status word unchanged. This includes a write that hits the address of a disabled set.
- R5: Writing a 1 to a status-word bit clears it and writing 0 leaves it alone. A capture of the same bit in the same cycle wins, so the bit stays set.
- R6: The set-enable register 0x190 reads back bits NS-1:0. Summary bit 8+i of 0x184 is raised one clock edge after set i's status AND enable is non-zero while set i is enabled. Status bits that are not enabled raise no summary.
- R7: Summary bits are write-one-to-clear and sticky. A clear while enabled vectors are still pending leaves the bit set. Clearing the vector status alone does not drop the bit.
- R8: INTx line k sets bit 24+k of 0x184 one edge after it is high. While the line is high a write-one to that bit has no effect. After the line falls the bit stays set until a write-one clears it.
- R9: The top-level enable register 0x180 holds bits 8+NS-1:8 and 27:24, and all of its other bits read zero.
- R10: `irq_out` is high exactly when some bit is set both in 0x184 and in 0x180.
- R11: Register addresses that are not mapped read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_valid | input | 1 | Inbound memory write present this cycle |
| cap_addr | input | 64 | Address of the inbound write |
| cap_data | input | 32 | Data of the inbound write; low bits select the vector |
| intx_level | input | 4 | Emulated INTA..INTD levels |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq_out | output | 1 | Aggregated interrupt |

## Verification
The assertions assume that the capture inputs and the register port are driven to known values in every cycle after reset. They also assume that a set's status word changes only through a capture or through a register write. The bench drives all inputs on the falling edge, keeps `cap_valid` and `reg_we` low outside its tasks, and never leaves an input undefined, so the stability properties only fire on a real fault. It gives each set a distinct capture address, so two sets are never hit by one write.

// File: rtl/msi_irq_aggregator.sv
module msi_irq_aggregator #(
  parameter int NS = 8,
  parameter int VW = 32,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_valid,
  input  logic [63:0]   cap_addr,
  input  logic [31:0]   cap_data,
  input  logic [3:0]    intx_level,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq_out
);
  localparam int VIW      = $clog2(VW);
  localparam int SUM_SH   = 8;
  localparam int INTX_SH  = 24;
  localparam int SET_BASE = 'hC00;
  localparam int SET_STEP = 'h10;
  localparam int HI_BASE  = 'hC80;
  localparam int HI_STEP  = 4;
  localparam logic [AW-1:0] A_TEN = AW'('h180);
  localparam logic [AW-1:0] A_TST = AW'('h184);
  localparam logic [AW-1:0] A_SEN = AW'('h190);

  function automatic logic [AW-1:0] set_reg(input int i, input int off);
    return AW'(SET_BASE + i * SET_STEP + off);
  endfunction

  function automatic logic [AW-1:0] hi_reg(input int i);
    return AW'(HI_BASE + i * HI_STEP);
  endfunction

  logic [NS-1:0][31:0]   cap_lo_q, cap_hi_q;
  logic [NS-1:0][VW-1:0] vstat_q, ven_q;
  logic [NS-1:0]         set_en_q, sum_q, sum_en_q, hit;
  logic [3:0]            istat_q, ien_q;
  logic                  we_ten, we_tst, we_sen;
  logic [31:0]           ten_word, tst_word;
  logic                  unused_bits;

  assign we_ten      = reg_we && reg_addr == A_TEN;
  assign we_tst      = reg_we && reg_addr == A_TST;
  assign we_sen      = reg_we && reg_addr == A_SEN;
  assign unused_bits = ^cap_data[31:VIW];

  for (genvar i = 0; i < NS; i++) begin : g_set
    logic [31:0]   lo_q, hi_q;
    logic [VW-1:0] st_q, en_q, vec_set, vec_clr;
    logic          sm_q;

    assign hit[i]   = cap_valid && set_en_q[i] && cap_addr == {hi_q, lo_q};
    assign vec_set  = hit[i] ? (VW'(1) << cap_data[VIW-1:0]) : '0;
    assign vec_clr  = (reg_we && reg_addr == set_reg(i, 4)) ? reg_wdata[VW-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q <= '0;
        hi_q <= '0;
        st_q <= '0;
        en_q <= '0;
        sm_q <= 1'b0;
      end else begin
        if (reg_we && reg_addr == set_reg(i, 0)) lo_q <= reg_wdata;
        if (reg_we && reg_addr == hi_reg(i))     hi_q <= reg_wdata;
        if (reg_we && reg_addr == set_reg(i, 8)) en_q <= reg_wdata[VW-1:0];
        st_q <= (st_q & ~vec_clr) | vec_set;
        sm_q <= (sm_q & ~(we_tst & reg_wdata[SUM_SH+i])) | (set_en_q[i] & (|(st_q & en_q)));
      end
    end

    assign cap_lo_q[i] = lo_q;
    assign cap_hi_q[i] = hi_q;
    assign vstat_q[i]  = st_q;
    assign ven_q[i]    = en_q;
    assign sum_q[i]    = sm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_en_q <= '0;
      sum_en_q <= '0;
      ien_q    <= '0;
      istat_q  <= '0;
    end else begin
      if (we_sen) set_en_q <= reg_wdata[NS-1:0];
      if (we_ten) begin
        sum_en_q <= reg_wdata[SUM_SH +: NS];
        ien_q    <= reg_wdata[INTX_SH +: 4];
      end
      istat_q <= intx_level | (istat_q & ~(we_tst ? reg_wdata[INTX_SH +: 4] : 4'b0));
    end
  end

  assign ten_word = (32'(sum_en_q) << SUM_SH) | (32'(ien_q) << INTX_SH);
  assign tst_word = (32'(sum_q) << SUM_SH) | (32'(istat_q) << INTX_SH);
  assign irq_out  = (|(sum_q & sum_en_q)) | (|(istat_q & ien_q));

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_TEN) reg_rdata = ten_word;
    if (reg_addr == A_TST) reg_rdata = tst_word;
    if (reg_addr == A_SEN) reg_rdata = 32'(set_en_q);
    for (int i = 0; i < NS; i++) begin
      if (reg_addr == set_reg(i, 0)) reg_rdata = cap_lo_q[i];
      if (reg_addr == set_reg(i, 4)) reg_rdata = 32'(vstat_q[i]);
      if (reg_addr == set_reg(i, 8)) reg_rdata = 32'(ven_q[i]);
      if (reg_addr == hi_reg(i))     reg_rdata = cap_hi_q[i];
    end
  end
endmodule

// File: rtl/msi_irq_aggregator_chk.sv
module msi_irq_aggregator_chk #(
  parameter int NS  = 8,
  parameter int VW  = 32,
  parameter int VIW = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cap_valid,
  input logic [63:0]           cap_addr,
  input logic [VIW-1:0]        cap_idx,
  input logic [3:0]            intx_level,
  input logic                  reg_we,
  input logic [NS-1:0][31:0]   cap_lo_q,
  input logic [NS-1:0][31:0]   cap_hi_q,
  input logic [NS-1:0][VW-1:0] vstat_q,
  input logic [NS-1:0][VW-1:0] ven_q,
  input logic [NS-1:0]         set_en_q,
  input logic [NS-1:0]         sum_q,
  input logic [NS-1:0]         sum_en_q,
  input logic [3:0]            istat_q,
  input logic [3:0]            ien_q,
  input logic                  irq_out
);
  logic [VIW-1:0] last_idx;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) last_idx <= '0;
    else        last_idx <= cap_idx;

  for (genvar i = 0; i < NS; i++) begin : g_chk
    AST_CAPTURE_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      cap_valid && set_en_q[i] && cap_addr == {cap_hi_q[i], cap_lo_q[i]} |=> vstat_q[i][last_idx]); // R3
    AST_DISABLED_SET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !set_en_q[i] && !reg_we |=> $stable(vstat_q[i])); // R4
    AST_SUMMARY_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      set_en_q[i] && (|(vstat_q[i] & ven_q[i])) |=> sum_q[i]); // R6
  end

  for (genvar k = 0; k < 4; k++) begin : g_intx
    AST_INTX_LEVEL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      intx_level[k] |=> istat_q[k]); // R8
  end

  AST_IRQ_QUIET_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    sum_en_q == '0 && ien_q == '0 |-> !irq_out); // R10
  AST_IRQ_ON_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sum_q & sum_en_q)) |-> irq_out); // R10
endmodule

bind msi_irq_aggregator msi_irq_aggregator_chk #(.NS(NS), .VW(VW), .VIW(VIW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_addr(cap_addr),
  .cap_idx(cap_data[VIW-1:0]), .intx_level(intx_level), .reg_we(reg_we),
  .cap_lo_q(cap_lo_q), .cap_hi_q(cap_hi_q), .vstat_q(vstat_q), .ven_q(ven_q),
  .set_en_q(set_en_q), .sum_q(sum_q), .sum_en_q(sum_en_q), .istat_q(istat_q),
  .ien_q(ien_q), .irq_out(irq_out)
);

// File: tb/msi_irq_aggregator_bench.sv
module msi_irq_aggregator_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_valid = 1'b0;
  logic [63:0] cap_addr = '0;
  logic [31:0] cap_data = '0;
  logic [3:0]  intx_level = '0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_irq_aggregator u_msi_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_addr(cap_addr),
    .cap_data(cap_data), .intx_level(intx_level), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out)
  );

  function automatic logic [11:0] a_lo(int i);  return 12'(12'hC00 + i*16);     endfunction
  function automatic logic [11:0] a_st(int i);  return 12'(12'hC00 + i*16 + 4); endfunction
  function automatic logic [11:0] a_en(int i);  return 12'(12'hC00 + i*16 + 8); endfunction
  function automatic logic [11:0] a_hi(int i);  return 12'(12'hC80 + i*4);      endfunction
  function automatic logic [63:0] tgt(int i);
    return {32'(32'h0000_0001 + i), 32'(32'hFE00_0000 + i*16)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic cap(input logic [63:0] a, input logic [31:0] d);
    cap_valid = 1'b1; cap_addr = a; cap_data = d;
    tick();
    cap_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] exp;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    for (int i = 0; i < NS; i++) begin
      rd(a_lo(i), d); chk("R1 lo", d, 0);
      rd(a_hi(i), d); chk("R1 hi", d, 0);
      rd(a_st(i), d); chk("R1 status", d, 0);
      rd(a_en(i), d); chk("R1 enable", d, 0);
    end
    rd(12'h180, d); chk("R1 top enable", d, 0);
    rd(12'h184, d); chk("R1 top status", d, 0);
    rd(12'h190, d); chk("R1 set enable", d, 0);
    chk("R1 irq", 32'(irq_out), 0);

    // R2 capture address programming
    for (int i = 0; i < NS; i++) begin
      wr(a_lo(i), tgt(i)[31:0]);
      wr(a_hi(i), tgt(i)[63:32]);
    end
    for (int i = 0; i < NS; i++) begin
      rd(a_lo(i), d); chk("R2 lo readback", d, tgt(i)[31:0]);
      rd(a_hi(i), d); chk("R2 hi readback", d, tgt(i)[63:32]);
    end

    // R4 hit on a disabled set is dropped
    cap(tgt(3), 32'd9);
    rd(a_st(3), d); chk("R4 disabled set", d, 0);

    wr(12'h190, 32'hFFFF_FFFF);
    rd(12'h190, d); chk("R6 set enable readback", d, 32'h0000_00FF);

    // R3 full sweep; data carries high bits to exercise mod 32
    for (int s = 0; s < NS; s++) begin
      exp = 0;
      for (int v = 0; v < 32; v++) begin
        cap(tgt(s), 32'(v + 32*(s+1)));
        exp = exp | (32'd1 << v);
        rd(a_st(s), d); chk("R3 sweep", d, exp);
      end
    end

    // R5 partial and full clears
    wr(a_st(2), 32'h0000_FFFF);
    rd(a_st(2), d); chk("R5 partial clear", d, 32'hFFFF_0000);
    wr(a_st(2), 32'h0);
    rd(a_st(2), d); chk("R5 zero write holds", d, 32'hFFFF_0000);
    for (int s = 0; s < NS; s++) begin
      wr(a_st(s), 32'hFFFF_FFFF);
      rd(a_st(s), d); chk("R5 full clear", d, 0);
    end
    rd(12'h184, d); chk("R6 no summary without enable", d, 0);

    // R5 capture beats clear in the same cycle
    cap(tgt(0), 32'd7);
    cap_valid = 1'b1; cap_addr = tgt(0); cap_data = 32'd7;
    reg_we = 1'b1; reg_addr = a_st(0); reg_wdata = 32'h80;
    tick();
    cap_valid = 1'b0; reg_we = 1'b0;
    rd(a_st(0), d); chk("R5 capture wins", d, 32'h80);
    wr(a_st(0), 32'h80);
    rd(a_st(0), d); chk("R5 clear after", d, 0);

    // R4 address that matches no set
    cap(tgt(0) + 64'd4, 32'd3);
    cap({tgt(5)[63:32] + 32'd1, tgt(5)[31:0]}, 32'd3);
    for (int s = 0; s < NS; s++) begin
      rd(a_st(s), d); chk("R4 miss", d, 0);
    end
    wr(12'h190, 32'h0000_00FB);
    cap(tgt(2), 32'd1);
    rd(a_st(2), d); chk("R4 disabled after enable", d, 0);
    wr(12'h190, 32'h0000_00FF);

    // R6, R7, R10 summary path on set 1
    wr(a_en(1), 32'h10);
    rd(a_en(1), d); chk("R2 enable readback", d, 32'h10);
    cap(tgt(1), 32'd5);
    tick();
    rd(12'h184, d); chk("R6 masked vector no summary", d, 0);
    cap(tgt(1), 32'd4);
    rd(12'h184, d); chk("R6 summary one edge late", d, 0);
    tick();
    rd(12'h184, d); chk("R6 summary raised", d, 32'h200);
    chk("R10 irq masked", 32'(irq_out), 0);
    wr(12'h180, 32'h200);
    #1; chk("R10 irq on", 32'(irq_out), 1);
    wr(12'h184, 32'h200);
    rd(12'h184, d); chk("R7 clear while pending", d, 32'h200);
    wr(a_st(1), 32'h10);
    rd(a_st(1), d); chk("R5 vector clear", d, 32'h20);
    rd(12'h184, d); chk("R7 summary sticky", d, 32'h200);
    wr(12'h184, 32'h200);
    rd(12'h184, d); chk("R7 summary cleared", d, 0);
    #1; chk("R10 irq off", 32'(irq_out), 0);

    // R8 INTx emulated level
    intx_level = 4'b0010;
    tick();
    rd(12'h184, d); chk("R8 intx set", d, 32'h0200_0000);
    wr(12'h180, 32'h0200_0000);
    #1; chk("R10 intx irq", 32'(irq_out), 1);
    wr(12'h184, 32'h0200_0000);
    rd(12'h184, d); chk("R8 clear while high", d, 32'h0200_0000);
    intx_level = 4'b0000;
    tick();
    rd(12'h184, d); chk("R8 sticky after fall", d, 32'h0200_0000);
    wr(12'h184, 32'h0200_0000);
    rd(12'h184, d); chk("R8 cleared", d, 0);
    #1; chk("R10 intx irq off", 32'(irq_out), 0);

    // R9 top enable field mask
    wr(12'h180, 32'hFFFF_FFFF);
    rd(12'h180, d); chk("R9 top enable mask", d, 32'h0F00_FF00);
    chk("R10 nothing pending", 32'(irq_out), 0);
    wr(12'h180, 32'h0);

    // R11 unmapped addresses
    rd(12'h200, d); chk("R11 unmapped", d, 0);
    rd(12'hC0C, d); chk("R11 gap in set block", d, 0);
    rd(12'hCA0, d); chk("R11 past hi block", d, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule